// File: doc/BRIEF.md
# Mailbox Message Slot

This block is a single slot of a mailbox between a host and an embedded processor. It holds a small circular queue of fixed-size message entries. A producer claims the next free entry, fills its words through a data window, and then commits the entry. The same command word that commits the entry carries the message length. A consumer reads the length and the words of the oldest entry, then releases it so that the next message becomes visible.

The slot has two register ports with the same map. Each port has a command register at byte 0, a status register at byte 4, and a data window from byte 8 with one 32-bit word per 4-byte step. On the producer port, the window addresses the entry being filled (the tail). On the consumer port, it addresses the oldest committed entry (the head). The status word reports the fill level, the length of the head message, and the log2 of the slot geometry, so software can size its transfers at run time.

Command bits in a command-register write:

| Bit | Name | Honoured on |
|-----|------|-------------|
| 24 | claim | producer port |
| 25 | purge | either port |
| 26 | commit (length in bits [7:0]) | producer port |
| 27 | release | consumer port |

Top module: `msg_slot`

## Requirements
- R1: After reset the slot is empty. The status word reads empty=1 (bit 1), full=0 (bit 0), occupancy 0 (bits [15:8]) and head length 0 (bits [23:16]).
- R2: Status bits [7:2] always hold log2 of the entry count, bits [31:28] always hold log2 of the words per entry, and bits [27:24] read 0.
- R3: Claim (command bit 24) followed by commit (command bit 26) on the producer port adds one entry. The commit stores bits [7:0] of the same write as the message length.
- R4: Consumer reads at byte 8+4*i return word i of the head entry. Messages come out in the order they were committed, including across wrap-around of the ring.
- R5: Release (command bit 27) on the consumer port drops the head entry, reduces occupancy by one, and exposes the next message and its length.
- R6: Full (status bit 0) is set when occupancy equals the entry count. A claim while full is ignored.
- R7: A commit with no claim pending is ignored.
- R8: A release while the slot is empty is ignored.
- R9: Producer data writes at byte 8+4*i go to word i of the claimed tail entry. While no claim is pending they are ignored; producer reads of the window return the tail entry's words.
- R10: Purge (command bit 25) on either port empties the slot and cancels a pending claim. It wins over any other command in the same cycle.
- R11: A commit and a release in the same cycle leave the occupancy unchanged.
- R12: Reads of the command register, and of addresses beyond the data window, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_wr | input | 1 | Producer write strobe |
| p_addr | input | ADDR_W | Producer byte address |
| p_wdata | input | 32 | Producer write data |
| p_rdata | output | 32 | Producer read data (combinational from p_addr) |
| c_wr | input | 1 | Consumer write strobe |
| c_addr | input | ADDR_W | Consumer byte address |
| c_wdata | input | 32 | Consumer write data |
| c_rdata | output | 32 | Consumer read data (combinational from c_addr) |

## Verification
The bench builds the slot with four entries of four words each (ENTRY_LOG2=2, WORD_LOG2=2). With this geometry a few messages fill the ring, so the full flag, the ignored claim and the head and tail pointers wrapping back to entry zero are all reached in a short run. Four-word entries also let a message use every window word, and let stale contents left by a cancelled claim be read back at the producer port.

// File: rtl/msg_slot.sv
`timescale 1ns/1ps
module msg_slot #(
  parameter int ENTRY_LOG2 = 2,
  parameter int WORD_LOG2  = 3,
  parameter int ADDR_W     = WORD_LOG2 + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p_wr,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [31:0]       p_wdata,
  output logic [31:0]       p_rdata,
  input  logic              c_wr,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [31:0]       c_wdata,
  output logic [31:0]       c_rdata
);
  localparam int ENTRIES = 1 << ENTRY_LOG2;
  localparam int WORDS   = 1 << WORD_LOG2;
  localparam int CNT_W   = ENTRY_LOG2 + 1;
  localparam int IDX_W   = ADDR_W - 2;
  localparam int MEM_W   = ENTRY_LOG2 + WORD_LOG2;
  localparam int CLAIM_B = 24;
  localparam int PURGE_B = 25;
  localparam int READY_B = 26;
  localparam int DISC_B  = 27;
  localparam logic [IDX_W-1:0] IDX_CMD = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_STS = IDX_W'(1);
  localparam logic [IDX_W-1:0] WIN_LO  = IDX_W'(2);
  localparam logic [IDX_W-1:0] WIN_HI  = IDX_W'(WORDS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ENTRIES);

  logic [31:0]           mem   [ENTRIES*WORDS];
  logic [7:0]            len_q [ENTRIES];
  logic [ENTRY_LOG2-1:0] head_q, tail_q;
  logic [CNT_W-1:0]      count_q;
  logic                  claimed_q;

  logic [IDX_W-1:0] p_idx, c_idx, p_rel, c_rel;
  logic             p_win, c_win, p_cmd, c_cmd;
  logic             full, empty, purge;
  logic             do_claim, do_ready, do_disc, do_wdat;
  logic [7:0]       head_len;
  logic [31:0]      status;

  assign p_idx = p_addr[ADDR_W-1:2];
  assign c_idx = c_addr[ADDR_W-1:2];
  assign p_rel = p_idx - WIN_LO;
  assign c_rel = c_idx - WIN_LO;
  assign p_win = (p_idx >= WIN_LO) && (p_idx < WIN_HI);
  assign c_win = (c_idx >= WIN_LO) && (c_idx < WIN_HI);
  assign p_cmd = p_wr && (p_idx == IDX_CMD);
  assign c_cmd = c_wr && (c_idx == IDX_CMD);

  assign full  = (count_q == CNT_MAX);
  assign empty = (count_q == '0);
  assign purge = (p_cmd && p_wdata[PURGE_B]) || (c_cmd && c_wdata[PURGE_B]);

  assign do_claim = p_cmd && p_wdata[CLAIM_B] && !claimed_q && !full && !purge;
  assign do_ready = p_cmd && p_wdata[READY_B] && claimed_q && !purge;
  assign do_disc  = c_cmd && c_wdata[DISC_B] && !empty && !purge;
  assign do_wdat  = p_wr && p_win && claimed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q    <= '0;
      tail_q    <= '0;
      count_q   <= '0;
      claimed_q <= 1'b0;
    end else if (purge) begin
      head_q    <= '0;
      tail_q    <= '0;
      count_q   <= '0;
      claimed_q <= 1'b0;
    end else begin
      if (do_claim) claimed_q <= 1'b1;
      if (do_ready) begin
        claimed_q <= 1'b0;
        tail_q    <= tail_q + 1'b1;
      end
      if (do_disc) head_q <= head_q + 1'b1;
      case ({do_ready, do_disc})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wdat) mem[MEM_W'({tail_q, p_rel[WORD_LOG2-1:0]})] <= p_wdata;
    if (do_ready) len_q[tail_q] <= p_wdata[7:0];
  end

  assign head_len = empty ? 8'h00 : len_q[head_q];
  assign status   = {4'(WORD_LOG2), 4'h0, head_len, 8'(count_q),
                     6'(ENTRY_LOG2), empty, full};

  always_comb begin
    p_rdata = 32'h0;
    if (p_idx == IDX_STS) p_rdata = status;
    else if (p_win)       p_rdata = mem[MEM_W'({tail_q, p_rel[WORD_LOG2-1:0]})];
  end

  always_comb begin
    c_rdata = 32'h0;
    if (c_idx == IDX_STS) c_rdata = status;
    else if (c_win)       c_rdata = mem[MEM_W'({head_q, c_rel[WORD_LOG2-1:0]})];
  end

  logic unused_bits;
  assign unused_bits = ^{p_addr[1:0], c_addr[1:0], p_wdata[23:8], p_wdata[31:28],
                         c_wdata[31:28], c_wdata[26], c_wdata[24:0],
                         p_rel[IDX_W-1:WORD_LOG2], c_rel[IDX_W-1:WORD_LOG2]};

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_MAX);
  // R6
  full_no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !claimed_q);
  // R7
  ready_unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_cmd && p_wdata[READY_B] && !claimed_q && !purge) |=> $stable(tail_q));
  // R8
  disc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_cmd && c_wdata[DISC_B] && empty && !purge) |=> $stable(head_q));
  // R10
  purge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    purge |=> (count_q == '0) && !claimed_q);
  // R3
  commit_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ready && !do_disc) |=> count_q == CNT_W'($past(count_q) + 1'b1));
endmodule

// File: tb/msg_slot_tb.sv
`timescale 1ns/1ps
module msg_slot_tb;
  localparam int EL = 2;
  localparam int WL = 2;
  localparam int AW = WL + 4;
  localparam int NE = 1 << EL;
  localparam int NW = 1 << WL;
  localparam logic [31:0] CLAIM = 32'h0100_0000;
  localparam logic [31:0] PURGE = 32'h0200_0000;
  localparam logic [31:0] READY = 32'h0400_0000;
  localparam logic [31:0] DISC  = 32'h0800_0000;

  logic clk = 0;
  logic rst_n = 0;
  logic p_wr = 0, c_wr = 0;
  logic [AW-1:0] p_addr = '0, c_addr = '0;
  logic [31:0] p_wdata = '0, c_wdata = '0;
  logic [31:0] p_rdata, c_rdata;

  msg_slot #(.ENTRY_LOG2(EL), .WORD_LOG2(WL), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .c_wr(c_wr), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata));

  always #2 clk = ~clk;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mmem [NE][NW];
  int mlen [NE];
  int mh = 0, mt = 0, mc = 0;
  bit mcl = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [7:0] hl;
    hl = (mc == 0) ? 8'h00 : 8'(mlen[mh]);
    return {4'(WL), 4'h0, hl, 8'(mc), 6'(EL), mc == 0, mc == NE};
  endfunction

  task automatic model(input bit pw, input logic [AW-1:0] pa, input logic [31:0] pd,
                       input bit cw, input logic [AW-1:0] ca, input logic [31:0] cd);
    int pi, ci;
    bit pc, cc;
    pi = int'(pa) / 4;
    ci = int'(ca) / 4;
    pc = pw && pi == 0;
    cc = cw && ci == 0;
    if (pw && pi >= 2 && pi < NW + 2 && mcl) mmem[mt][pi-2] = pd;
    if ((pc && pd[25]) || (cc && cd[25])) begin
      mh = 0; mt = 0; mc = 0; mcl = 0;
    end else begin
      bit rdy, clm, dsc;
      rdy = pc && pd[26] && mcl;
      clm = pc && pd[24] && !mcl && mc < NE;
      dsc = cc && cd[27] && mc > 0;
      if (rdy) begin
        mlen[mt] = int'(pd[7:0]); mt = (mt + 1) % NE; mc++; mcl = 0;
      end
      if (clm) mcl = 1;
      if (dsc) begin
        mh = (mh + 1) % NE; mc--;
      end
    end
  endtask

  task automatic cycle(input string req, input bit pw, input logic [AW-1:0] pa, input logic [31:0] pd,
                       input bit cw, input logic [AW-1:0] ca, input logic [31:0] cd);
    @(negedge clk);
    p_wr = pw; p_addr = pa; p_wdata = pd;
    c_wr = cw; c_addr = ca; c_wdata = cd;
    @(posedge clk);
    model(pw, pa, pd, cw, ca, cd);
    #0.5;
    p_wr = 0; c_wr = 0;
    p_addr = AW'(4); c_addr = AW'(4);
    #0.5;
    check({req, " producer status"}, p_rdata, exp_status());
    check({req, " consumer status"}, c_rdata, exp_status());
  endtask

  task automatic pcmd(input string req, input logic [31:0] d);
    cycle(req, 1, '0, d, 0, '0, '0);
  endtask

  task automatic ccmd(input string req, input logic [31:0] d);
    cycle(req, 0, '0, '0, 1, '0, d);
  endtask

  task automatic pdata(input string req, input int i, input logic [31:0] d);
    cycle(req, 1, AW'(8 + 4*i), d, 0, '0, '0);
  endtask

  task automatic rd_c(input string req, input int i);
    c_addr = AW'(8 + 4*i);
    #0.25;
    check(req, c_rdata, mmem[mh][i]);
  endtask

  task automatic rd_p(input string req, input int i);
    p_addr = AW'(8 + 4*i);
    #0.25;
    check(req, p_rdata, mmem[mt][i]);
  endtask

  task automatic send(input int n, input logic [31:0] base);
    pcmd("R3 claim", CLAIM);
    for (int i = 0; i < n; i++) pdata("R9 data write", i, base + 32'(i));
    pcmd("R3 commit", READY | 32'(n));
  endtask

  task automatic recv();
    int n;
    n = mlen[mh];
    for (int i = 0; i < n; i++) rd_c("R4 head word", i);
    ccmd("R5 release", DISC);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < NE; e++) begin
      mlen[e] = 0;
      for (int w = 0; w < NW; w++) mmem[e][w] = 32'h0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    p_addr = AW'(4); c_addr = AW'(4);
    #0.5;
    check("R1 reset producer status", p_rdata, 32'h2000_000A);
    check("R2 reset consumer status", c_rdata, 32'h2000_000A);

    pcmd("R7 commit without claim", READY | 32'd3);
    ccmd("R8 release while empty", DISC);

    send(3, 32'hA000_0000);
    check("R3 head length", c_rdata[23:16], 32'(8'd3));
    send(2, 32'hB000_0000);
    check("R3 occupancy two", c_rdata[15:8], 32'(8'd2));
    recv();
    check("R5 next length", c_rdata[23:16], 32'(8'd2));
    recv();

    for (int k = 0; k < NE; k++) send(k + 1, 32'hC000_0000 + 32'(k << 8));
    check("R6 full flag", c_rdata[0], 32'd1);
    pcmd("R6 claim while full", CLAIM);
    pdata("R9 write without claim", 0, 32'hDEAD_0000);
    rd_p("R9 tail word unchanged", 0);
    pcmd("R7 commit while full", READY | 32'd1);

    recv();
    pcmd("R11 claim", CLAIM);
    pdata("R11 data", 0, 32'hE000_0001);
    cycle("R11 commit with release", 1, '0, READY | 32'd1, 1, '0, DISC);
    check("R11 occupancy", c_rdata[15:8], 32'(8'd3));
    recv(); recv(); recv();
    check("R4 empty after wrap", c_rdata[1], 32'd1);

    pcmd("R10 claim", CLAIM);
    send(0, 32'h0);
    pcmd("R10 claim before purge", CLAIM);
    pdata("R10 data", 0, 32'hF000_0001);
    ccmd("R10 consumer purge", PURGE | DISC);
    pcmd("R10 commit after purge", READY | 32'd1);
    pcmd("R9 claim", CLAIM);
    pdata("R9 data", 0, 32'hAAAA_5555);
    pcmd("R10 producer purge", PURGE | READY | 32'd1);
    pdata("R9 write after cancel", 0, 32'hBBBB_0000);
    rd_p("R9 stale word kept", 0);

    send(4, 32'h1234_0000);
    p_addr = '0; c_addr = '0;
    #0.25;
    check("R12 producer command read", p_rdata, 32'h0);
    check("R12 consumer command read", c_rdata, 32'h0);
    c_addr = AW'(8 + 4*NW);
    #0.25;
    check("R12 beyond window", c_rdata, 32'h0);
    recv();
    check("R2 geometry fields", c_rdata & 32'hFF00_00FC, 32'h2000_0008);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule